// File: doc/BRIEF.md
# Strobed fuse read port

This block is a software-driven read port for a one-time-programmable fuse array. It has no sequencer of its own. A small memory-mapped slave exposes a control word that drives each fuse pin directly: an active-low select, an active-low program enable, a load line, a strobe line and a 10-bit byte address. A second word returns the last byte the strobe captured.

To read a byte, software performs these steps in order:
1. Select the array in read mode (load high, program enable high).
2. Place the address.
3. Raise strobe.
4. Fetch the data word.
5. Drop strobe.

Only a strobe transition from low to high captures data, and only while the array is selected in read mode. Parking the select and program-enable lines high puts the port in standby.

The fuse contents are held in a parameterized internal model. That model is loaded only through a separate backdoor write port and is never touched by bus traffic. Byte addresses at or beyond the model depth read as zero.

Top module: `fuse_rd_port`

## Requirements
- R1: After reset, the control word reads 0x0000_0009 (select and program enable high, all else zero), the data word reads 0 and `standby_o` is high.
- R2: A bus write to offset 0x00 stores the control fields, and the control word reads back only those fields, with every other bit zero. The fields are: bit 0 select (active low), bit 1 strobe, bit 2 load, bit 3 program enable (active low) and bits 15:6 address.
- R3: When strobe goes from 0 to 1 while select is 0, load is 1 and program enable is 1, the fuse byte at the control address is captured. It appears in bits 7:0 of offset 0x04, with bits 31:8 zero, from the second clock edge after the write.
- R4: A strobe rise does not change the data word if select is 1, if load is 0 or if program enable is 0.
- R5: Rewriting the control word with strobe already 1 does not capture again, even with a new address. A new capture needs strobe to return to 0 first.
- R6: `standby_o` is high exactly when select is 1 and program enable is 1.
- R7: A capture at an address equal to or above `FUSE_DEPTH` yields 0.
- R8: Writes to offset 0x04 or to any unmapped offset change neither the control word, the data word nor the fuse contents. Reads of unmapped offsets return 0.
- R9: If a backdoor write hits the captured address on the same clock edge that captures it, the data word takes the byte held before that write. A later capture returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write (1) or read (0) |
| addr_i | input | BUS_AW | Bus byte offset |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, combinational from addr_i |
| bd_we_i | input | 1 | Backdoor fuse write enable |
| bd_addr_i | input | 10 | Backdoor fuse byte address |
| bd_data_i | input | 8 | Backdoor fuse byte |
| standby_o | output | 1 | Array parked in standby |

## Verification
A fuse capture and a backdoor update of the same byte can land on one clock edge. The bench provokes this by issuing the strobe-raising write and then driving the backdoor write in the following cycle, which is the capture edge. The data word must then show the byte held before the update, and a second strobe pulse must show the new byte. A bus read of the data word in the capture cycle is also judged to return the previous byte, because the read path is combinational from the stored value.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int REG_W    = 32;
  localparam int FUSE_AW  = 10;
  localparam int FUSE_DW  = 8;
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_DATA = 'h04;
  localparam int CSB_BIT   = 0;
  localparam int STB_BIT   = 1;
  localparam int LOAD_BIT  = 2;
  localparam int PGENB_BIT = 3;
  localparam int ADR_LSB   = 6;

  typedef struct packed {
    logic [FUSE_AW-1:0] addr;
    logic               pgenb;
    logic               load;
    logic               strobe;
    logic               csb;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{addr: '0, pgenb: 1'b1, load: 1'b0, strobe: 1'b0, csb: 1'b1};

  function automatic ctrl_t ctrl_unpack(logic [REG_W-1:0] w);
    ctrl_t c;
    c.addr   = w[ADR_LSB +: FUSE_AW];
    c.pgenb  = w[PGENB_BIT];
    c.load   = w[LOAD_BIT];
    c.strobe = w[STB_BIT];
    c.csb    = w[CSB_BIT];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_pack(ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[ADR_LSB +: FUSE_AW] = c.addr;
    w[PGENB_BIT] = c.pgenb;
    w[LOAD_BIT]  = c.load;
    w[STB_BIT]   = c.strobe;
    w[CSB_BIT]   = c.csb;
    return w;
  endfunction
endpackage

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic               clk_i,
  input  logic               bd_we_i,
  input  logic [FUSE_AW-1:0] bd_addr_i,
  input  logic [FUSE_DW-1:0] bd_data_i,
  input  logic [FUSE_AW-1:0] rd_addr_i,
  output logic [FUSE_DW-1:0] rd_data_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [FUSE_AW:0] DEPTH_L = (FUSE_AW+1)'(DEPTH);

  logic [FUSE_DW-1:0] mem [DEPTH];
  logic bd_in, rd_in;

  assign bd_in = {1'b0, bd_addr_i} < DEPTH_L;
  assign rd_in = {1'b0, rd_addr_i} < DEPTH_L;

  always_ff @(posedge clk_i) begin
    if (bd_we_i && bd_in) mem[bd_addr_i[IDX_W-1:0]] <= bd_data_i;
  end

  // out-of-range bytes read as blank fuses
  assign rd_data_o = rd_in ? mem[rd_addr_i[IDX_W-1:0]] : '0;
endmodule

// File: rtl/fuse_strobe_ctl.sv
module fuse_strobe_ctl
  import fuse_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ctrl_t              ctrl_i,
  input  logic [FUSE_DW-1:0] fuse_i,
  output logic [FUSE_DW-1:0] dout_o,
  output logic               fire_o
);
  logic strb_d;
  logic rd_mode;

  assign rd_mode = !ctrl_i.csb && ctrl_i.load && ctrl_i.pgenb;
  assign fire_o  = ctrl_i.strobe && !strb_d && rd_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_d <= 1'b0;
      dout_o <= '0;
    end else begin
      strb_d <= ctrl_i.strobe;
      if (fire_o) dout_o <= fuse_i;
    end
  end
endmodule

// File: rtl/fuse_reg_if.sv
module fuse_reg_if
  import fuse_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [BUS_AW-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [FUSE_DW-1:0] dout_i,
  output ctrl_t              ctrl_o
);
  localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(OFS_CTRL);
  localparam logic [BUS_AW-1:0] A_DATA = BUS_AW'(OFS_DATA);

  logic sel_ctrl, sel_data;
  assign sel_ctrl = addr_i == A_CTRL;
  assign sel_data = addr_i == A_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ctrl_o <= CTRL_RST;
    else if (req_i && we_i && sel_ctrl) ctrl_o <= ctrl_unpack(wdata_i);
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (sel_ctrl)      rdata_o = ctrl_pack(ctrl_o);
      else if (sel_data) rdata_o = {{(REG_W-FUSE_DW){1'b0}}, dout_i};
    end
  end
endmodule

// File: rtl/fuse_rd_port.sv
module fuse_rd_port
  import fuse_pkg::*;
#(
  parameter int BUS_AW     = 8,
  parameter int FUSE_DEPTH = 512
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [BUS_AW-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic               bd_we_i,
  input  logic [FUSE_AW-1:0] bd_addr_i,
  input  logic [FUSE_DW-1:0] bd_data_i,
  output logic               standby_o
);
  ctrl_t              ctrl;
  logic [FUSE_DW-1:0] fuse_byte;
  logic [FUSE_DW-1:0] dout;
  logic               fire;

  fuse_reg_if #(.BUS_AW(BUS_AW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .dout_i(dout), .ctrl_o(ctrl)
  );

  fuse_array #(.DEPTH(FUSE_DEPTH)) u_array (
    .clk_i, .bd_we_i, .bd_addr_i, .bd_data_i,
    .rd_addr_i(ctrl.addr), .rd_data_o(fuse_byte)
  );

  fuse_strobe_ctl u_strobe (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .fuse_i(fuse_byte),
    .dout_o(dout), .fire_o(fire)
  );

  assign standby_o = ctrl.csb & ctrl.pgenb;
endmodule

// File: rtl/fuse_rd_port_chk.sv
module fuse_rd_port_chk
  import fuse_pkg::*;
#(
  parameter int BUS_AW     = 8,
  parameter int FUSE_DEPTH = 512
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [BUS_AW-1:0]  addr_i,
  input logic [REG_W-1:0]   wdata_i,
  input logic [REG_W-1:0]   rdata_o,
  input logic               standby_o,
  input ctrl_t              ctrl,
  input logic [FUSE_DW-1:0] dout
);
  localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(OFS_CTRL);
  localparam logic [BUS_AW-1:0] A_DATA = BUS_AW'(OFS_DATA);
  localparam logic [FUSE_AW:0]  DEPTH_L = (FUSE_AW+1)'(FUSE_DEPTH);

  logic prev_stb;
  logic cap;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_stb <= 1'b0;
    else         prev_stb <= ctrl.strobe;
  end
  assign cap = ctrl.strobe && !prev_stb && !ctrl.csb && ctrl.load && ctrl.pgenb;

  // R2
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == A_CTRL |=>
      ctrl.addr == $past(wdata_i[ADR_LSB +: FUSE_AW]) && ctrl.csb == $past(wdata_i[CSB_BIT]) &&
      ctrl.strobe == $past(wdata_i[STB_BIT]) && ctrl.load == $past(wdata_i[LOAD_BIT]) &&
      ctrl.pgenb == $past(wdata_i[PGENB_BIT]));

  // R8
  other_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i != A_CTRL |=> $stable(ctrl));

  // R8
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i != A_CTRL && addr_i != A_DATA |-> rdata_o == '0);

  // R3
  data_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == A_DATA |-> rdata_o == {{(REG_W-FUSE_DW){1'b0}}, dout});

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(dout));

  // R7
  oor_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap && {1'b0, ctrl.addr} >= DEPTH_L |=> dout == '0);

  // R6
  standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o == (ctrl.csb && ctrl.pgenb));
endmodule

bind fuse_rd_port fuse_rd_port_chk #(.BUS_AW(BUS_AW), .FUSE_DEPTH(FUSE_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .standby_o(standby_o),
  .ctrl(ctrl), .dout(dout)
);

// File: tb/sim_fuse_rd_port.sv
module sim_fuse_rd_port;
  localparam int BUS_AW = 8;
  localparam int DEPTH  = 48;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        bd_we_i = 1'b0;
  logic [9:0]  bd_addr_i = '0;
  logic [7:0]  bd_data_i = '0;
  logic        standby_o;

  int checks = 0, failures = 0;

  fuse_rd_port #(.BUS_AW(BUS_AW), .FUSE_DEPTH(DEPTH)) u0 (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] fz(int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  function automatic logic [31:0] cw(int a, bit pg, bit ld, bit st, bit cs);
    return {16'b0, 10'(a), 2'b00, pg, ld, st, cs};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    #2 d = rdata_o;
    @(posedge clk_i); #1 req_i = 0;
  endtask

  task automatic bd_wr(int a, logic [7:0] d);
    @(negedge clk_i); bd_we_i = 1; bd_addr_i = 10'(a); bd_data_i = d;
    @(negedge clk_i); bd_we_i = 0;
  endtask

  task automatic fuse_read(int a, output logic [31:0] d);
    bus_wr(8'h00, cw(a, 1, 1, 0, 0));
    bus_wr(8'h00, cw(a, 1, 1, 1, 0));
    bus_rd(8'h04, d);
    bus_wr(8'h00, cw(a, 1, 1, 0, 0));
  endtask

  task automatic finish_up();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1 reset state
    bus_rd(8'h00, d); check("R1 ctrl", d, 32'h9);
    bus_rd(8'h04, d); check("R1 dout", d, 32'h0);
    check("R1 standby", {31'b0, standby_o}, 32'h1);

    for (int a = 0; a < DEPTH; a++) bd_wr(a, fz(a));

    // R2 field storage, R6 standby over all low-bit combos
    for (int v = 0; v < 16; v++) begin
      bus_wr(8'h00, 32'hFFFF_0000 | 32'((v * 71) & 10'h3FF) << 6 | 32'h30 | 32'(v));
      bus_rd(8'h00, d);
      check("R2 readback", d, (32'((v * 71) & 10'h3FF) << 6) | 32'(v));
      check("R6 standby", {31'b0, standby_o}, {31'b0, v[0] & v[3]});
    end
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h00, d); check("R2 all ones", d, 32'h0000_FFCF);
    bus_wr(8'h00, cw(0, 1, 1, 0, 0));

    // R3 / R7 sweep every address
    for (int a = 0; a < 1024; a++) begin
      fuse_read(a, d);
      if (a < DEPTH) check("R3 capture", d, {24'b0, fz(a)});
      else           check("R7 out of range", d, 32'h0);
    end

    // R4 disqualified strobes
    fuse_read(5, d); check("R3 preset", d, {24'b0, fz(5)});
    bus_wr(8'h00, cw(9, 1, 1, 0, 1)); bus_wr(8'h00, cw(9, 1, 1, 1, 1));
    bus_rd(8'h04, d); check("R4 csb high", d, {24'b0, fz(5)});
    bus_wr(8'h00, cw(9, 1, 0, 0, 0)); bus_wr(8'h00, cw(9, 1, 0, 1, 0));
    bus_rd(8'h04, d); check("R4 load low", d, {24'b0, fz(5)});
    bus_wr(8'h00, cw(9, 0, 1, 0, 0)); bus_wr(8'h00, cw(9, 0, 1, 1, 0));
    bus_rd(8'h04, d); check("R4 pgenb low", d, {24'b0, fz(5)});

    // R5 strobe held high
    bus_wr(8'h00, cw(7, 1, 1, 0, 0));
    bus_wr(8'h00, cw(7, 1, 1, 1, 0));
    bus_wr(8'h00, cw(12, 1, 1, 1, 0));
    bus_rd(8'h04, d); check("R5 no recapture", d, {24'b0, fz(7)});
    bus_wr(8'h00, cw(12, 1, 1, 0, 0));
    bus_wr(8'h00, cw(12, 1, 1, 1, 0));
    bus_rd(8'h04, d); check("R5 new rise", d, {24'b0, fz(12)});
    bus_wr(8'h00, cw(12, 1, 1, 0, 0));

    // R8 ignored writes and unmapped reads
    bus_wr(8'h04, 32'hDEAD_BEEF);
    bus_rd(8'h04, d); check("R8 data write ignored", d, {24'b0, fz(12)});
    bus_wr(8'h10, 32'h0000_FFFF);
    bus_rd(8'h00, d); check("R8 unmapped write", d, cw(12, 1, 1, 0, 0));
    bus_rd(8'h08, d); check("R8 unmapped read 08", d, 32'h0);
    bus_rd(8'hFC, d); check("R8 unmapped read FC", d, 32'h0);
    fuse_read(12, d); check("R8 fuse untouched", d, {24'b0, fz(12)});

    // R9 backdoor write on the capture edge
    bus_wr(8'h00, cw(20, 1, 1, 0, 0));
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = 8'h00; wdata_i = cw(20, 1, 1, 1, 0);
    @(negedge clk_i); req_i = 0; we_i = 0;
    bd_we_i = 1; bd_addr_i = 10'd20; bd_data_i = 8'hA5;
    @(negedge clk_i); bd_we_i = 0;
    bus_rd(8'h04, d); check("R9 old byte", d, {24'b0, fz(20)});
    bus_wr(8'h00, cw(20, 1, 1, 0, 0));
    fuse_read(20, d); check("R9 new byte", d, 32'hA5);

    // R6 standby entry
    bus_wr(8'h00, cw(0, 1, 0, 0, 1));
    check("R6 standby entry", {31'b0, standby_o}, 32'h1);

    finish_up();
  end
endmodule